// File: doc/BRIEF.md
# Performance Monitoring Counter Bank

The block holds a set of programmable general event counters and a set of fixed-function counters. Every cycle each counter may add a small increment from the event side. Whether it adds depends on three things: a shared global enable word, the counter's own enable, and a filter on the current privilege level (supervisor or user). A general counter picks one of several event lanes through its selector. It can also apply a threshold, in which case it adds one on any cycle whose increment reaches the threshold.

When a counter rolls over from all ones to zero, the block sets a sticky bit in a global overflow status word. Software clears that bit by writing ones to a separate clear address. An interrupt level stays high while any status bit whose counter asked for an interrupt remains set. Software uses a simple register port. Each general counter has two write aliases: a legacy alias that sign-extends the low 32 bits, and a full-width alias that rejects values too wide for the counter. A separate read-index port serves the read-counter instruction. Bit 30 of the index chooses the counter type, bit 31 chooses a 32-bit fast result, and an unknown index is flagged.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset, every counter, event select, fixed control, global enable and status word reads 0, and `irq` and `reg_err` are low.
- R2: General counter g has its event select at address 0x00+g, laid out as follows: bits [2:0] pick event lane `ev_inc[3*lane +: 3]`, bit 16 = count at supervisor level (`priv_user`=0), bit 17 = count at user level (`priv_user`=1), bit 18 = interrupt on overflow, bit 19 = enable, bits [23:20] = threshold. The counter adds its lane's increment only when the enable bit, the bit for the current level and its global bit are all set.
- R3: The global enable word is at address 0x31. General counter g uses bit g. Fixed counter j uses bit 32+j. A counter whose global bit is clear holds its value.
- R4: The fixed control word is at address 0x30, with nibble j at bits [4j+3:4j]. Bit 0 of the nibble counts at supervisor level, bit 1 counts at user level, and bit 3 requests an interrupt on overflow. Fixed counter j adds `fix_inc[3*j +: 3]`. Fixed counter j reads and writes at address 0x20+j, and a write stores the low 48 bits.
- R5: With a non-zero threshold, a general counter adds exactly 1 on cycles where its lane increment is at least the threshold, and adds 0 on other cycles.
- R6: A carry out of the 48-bit counter sets that counter's bit (same mapping as R3) in the status word at 0x32. Writing ones to 0x33 clears those bits. An overflow in the same cycle as a clear leaves its bit set.
- R7: `irq` is high exactly while some status bit is set whose counter has its interrupt bit set. An overflow with the interrupt bit clear changes only the status word.
- R8: A write to the legacy alias 0x10+g stores bits [31:0] sign-extended to 48 bits. A read at either alias returns the counter zero-extended.
- R9: A write to the full alias 0x18+g stores the value when bits [63:48] are zero. Otherwise the counter is unchanged and `reg_err` pulses high for the cycle after the write.
- R10: `rd_idx` bit 30 selects fixed counters and bits [29:0] give the number. With bit 31 set, `rd_data` carries only bits [31:0]. A number out of range sets `rd_err` and returns 0.
- R11: A write to a running counter takes priority over that cycle's increment, and counting resumes from the written value on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_user | input | 1 | Current level: 1 user, 0 supervisor |
| ev_inc | input | 24 | Eight 3-bit per-cycle event increments |
| fix_inc | input | 9 | Three 3-bit increments for the fixed counters |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| reg_err | output | 1 | Rejected full-width write, one-cycle pulse |
| rd_idx | input | 32 | Read-counter index |
| rd_data | output | 64 | Read-counter result |
| rd_err | output | 1 | Read-counter index out of range |
| irq | output | 1 | Overflow interrupt level |

## Verification
Most internal faults show up within one clock edge. A counter that counts outside its enable, level or threshold conditions reads back wrong at the next access. A status bit that is lost or stays set is visible in the status word, and on `irq` in the cycle right after the overflow edge. Errors in the write alias and the read index can be seen at once on readback and on the two error outputs. A fault in the rollover carry shows only once a counter is preset near all ones, so the bench runs those presets on both counter types.

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank #(
  parameter int NGP   = 4,
  parameter int NFIX  = 3,
  parameter int CW    = 48,
  parameter int IW    = 3,
  parameter int NEV   = 8,
  parameter int FBASE = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               priv_user,
  input  logic [NEV*IW-1:0]  ev_inc,
  input  logic [NFIX*IW-1:0] fix_inc,
  input  logic               reg_wr,
  input  logic [7:0]         reg_addr,
  input  logic [63:0]        reg_wdata,
  output logic [63:0]        reg_rdata,
  output logic               reg_err,
  input  logic [31:0]        rd_idx,
  output logic [63:0]        rd_data,
  output logic               rd_err,
  output logic               irq
);
  localparam int GW  = FBASE + NFIX;
  localparam int ESW = $clog2(NEV);
  localparam int CMW = IW + 1;
  localparam logic [7:0] A_SEL  = 8'h00;
  localparam logic [7:0] A_LEG  = 8'h10;
  localparam logic [7:0] A_FULL = 8'h18;
  localparam logic [7:0] A_FIX  = 8'h20;
  localparam logic [7:0] A_FCTL = 8'h30;
  localparam logic [7:0] A_GCTL = 8'h31;
  localparam logic [7:0] A_GST  = 8'h32;
  localparam logic [7:0] A_GCLR = 8'h33;

  logic [CW-1:0]     gcnt [NGP];
  logic [CW-1:0]     fcnt [NFIX];
  logic [31:0]       evsel [NGP];
  logic [4*NFIX-1:0] fctl;
  logic [GW-1:0]     gctl, gstat, ovf, inten, clr;
  logic [NGP-1:0]    ovf_g, ie_g;
  logic [NFIX-1:0]   ovf_f, ie_f;
  logic [IW-1:0]     evv [NEV];

  wire too_wide = |reg_wdata[63:CW];

  for (genvar e = 0; e < NEV; e++) begin : g_lane
    assign evv[e] = ev_inc[e*IW +: IW];
  end

  for (genvar g = 0; g < NGP; g++) begin : g_gp
    wire [IW-1:0]  inc    = evv[evsel[g][ESW-1:0]];
    wire [CMW-1:0] cm     = evsel[g][20 +: CMW];
    wire           live   = gctl[g] & evsel[g][19] & (priv_user ? evsel[g][17] : evsel[g][16]);
    wire [IW-1:0]  amt    = !live ? '0 : (cm == '0) ? inc : ({1'b0, inc} >= cm) ? IW'(1) : '0;
    wire [CW:0]    sum    = {1'b0, gcnt[g]} + {{(CW+1-IW){1'b0}}, amt};
    wire           w_leg  = reg_wr && reg_addr == A_LEG + 8'(g);
    wire           w_full = reg_wr && reg_addr == A_FULL + 8'(g) && !too_wide;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        gcnt[g]  <= '0;
        evsel[g] <= '0;
      end else begin
        if (reg_wr && reg_addr == A_SEL + 8'(g)) evsel[g] <= reg_wdata[31:0];
        if (w_leg)       gcnt[g] <= {{(CW-32){reg_wdata[31]}}, reg_wdata[31:0]};
        else if (w_full) gcnt[g] <= reg_wdata[CW-1:0];
        else             gcnt[g] <= sum[CW-1:0];
      end

    assign ovf_g[g] = sum[CW] & ~w_leg & ~w_full;
    assign ie_g[g]  = evsel[g][18];
  end

  for (genvar f = 0; f < NFIX; f++) begin : g_fix
    wire          live = gctl[FBASE+f] & (priv_user ? fctl[4*f+1] : fctl[4*f]);
    wire [IW-1:0] amt  = live ? fix_inc[f*IW +: IW] : '0;
    wire [CW:0]   sum  = {1'b0, fcnt[f]} + {{(CW+1-IW){1'b0}}, amt};
    wire          w    = reg_wr && reg_addr == A_FIX + 8'(f);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)  fcnt[f] <= '0;
      else if (w)  fcnt[f] <= reg_wdata[CW-1:0];
      else         fcnt[f] <= sum[CW-1:0];

    assign ovf_f[f] = sum[CW] & ~w;
    assign ie_f[f]  = fctl[4*f+3];
  end

  always_comb begin
    ovf   = '0;
    inten = '0;
    ovf[NGP-1:0]     = ovf_g;
    ovf[FBASE +: NFIX]   = ovf_f;
    inten[NGP-1:0]   = ie_g;
    inten[FBASE +: NFIX] = ie_f;
  end

  assign clr = (reg_wr && reg_addr == A_GCLR) ? reg_wdata[GW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gctl    <= '0;
      fctl    <= '0;
      gstat   <= '0;
      reg_err <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_GCTL) gctl <= reg_wdata[GW-1:0];
      if (reg_wr && reg_addr == A_FCTL) fctl <= reg_wdata[4*NFIX-1:0];
      gstat   <= (gstat & ~clr) | ovf;
      reg_err <= reg_wr && reg_addr >= A_FULL && reg_addr < A_FULL + 8'(NGP) && too_wide;
    end

  assign irq = |(gstat & inten);

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NGP; i++) begin
      if (reg_addr == A_SEL + 8'(i)) reg_rdata = {32'b0, evsel[i]};
      if (reg_addr == A_LEG + 8'(i) || reg_addr == A_FULL + 8'(i))
        reg_rdata = {{(64-CW){1'b0}}, gcnt[i]};
    end
    for (int i = 0; i < NFIX; i++)
      if (reg_addr == A_FIX + 8'(i)) reg_rdata = {{(64-CW){1'b0}}, fcnt[i]};
    if (reg_addr == A_FCTL) reg_rdata = {{(64-4*NFIX){1'b0}}, fctl};
    if (reg_addr == A_GCTL) reg_rdata = {{(64-GW){1'b0}}, gctl};
    if (reg_addr == A_GST)  reg_rdata = {{(64-GW){1'b0}}, gstat};
  end

  logic          hit;
  logic [CW-1:0] val;
  always_comb begin
    hit = 1'b0;
    val = '0;
    for (int i = 0; i < NGP; i++)
      if (!rd_idx[30] && rd_idx[29:0] == 30'(i)) begin hit = 1'b1; val = gcnt[i]; end
    for (int i = 0; i < NFIX; i++)
      if (rd_idx[30] && rd_idx[29:0] == 30'(i)) begin hit = 1'b1; val = fcnt[i]; end
    rd_err  = !hit;
    rd_data = !hit ? '0 : rd_idx[31] ? {32'b0, val[31:0]} : {{(64-CW){1'b0}}, val};
  end
endmodule

// File: rtl/perf_ctr_bank_chk.sv
module perf_ctr_bank_chk #(
  parameter int GW = 35,
  parameter int CW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [7:0]    reg_addr,
  input logic          reg_err,
  input logic          irq,
  input logic [31:0]   rd_idx,
  input logic [63:0]   rd_data,
  input logic          rd_err,
  input logic [GW-1:0] gstat,
  input logic          gate0,
  input logic [CW-1:0] cnt0
);
  p_gate_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate0 && !(reg_wr && (reg_addr == 8'h10 || reg_addr == 8'h18))) |=> cnt0 == $past(cnt0));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 8'h33) |=> (gstat & $past(gstat)) == $past(gstat));

  p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gstat != '0);

  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err |-> $past(reg_wr));

  p_fast_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx[31] && !rd_err) |-> rd_data[63:32] == 32'b0);

  p_bad_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> rd_data == 64'b0);
endmodule

bind perf_ctr_bank perf_ctr_bank_chk #(.GW(GW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_err(reg_err), .irq(irq), .rd_idx(rd_idx), .rd_data(rd_data),
  .rd_err(rd_err), .gstat(gstat), .gate0(gctl[0]), .cnt0(gcnt[0])
);

// File: tb/perf_ctr_bank_tb.sv
module perf_ctr_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        priv_user = 1'b0;
  logic [23:0] ev_inc = '0;
  logic [8:0]  fix_inc = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata, rd_data;
  logic        reg_err, rd_err, irq;
  logic [31:0] rd_idx = '0;
  int checks = 0, failures = 0;
  logic [63:0] v;

  always #2 clk = ~clk;

  perf_ctr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .priv_user(priv_user), .ev_inc(ev_inc),
    .fix_inc(fix_inc), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_err(rd_err), .irq(irq)
  );

  localparam logic [7:0]  VA [6] = '{8'h10, 8'h10, 8'h18, 8'h18, 8'h18, 8'h10};
  localparam logic [63:0] VD [6] = '{64'h0000_0000_7FFF_FFFF, 64'hFFFF_FF01_8000_0000,
                                     64'h0000_0123_4567_89AB, 64'h0001_0000_0000_0005,
                                     64'h0000_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0003};
  localparam logic [63:0] VE [6] = '{64'h0000_0000_7FFF_FFFF, 64'h0000_FFFF_8000_0000,
                                     64'h0000_0123_4567_89AB, 64'h0000_0123_4567_89AB,
                                     64'h0000_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0003};
  localparam logic        VR [6] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic lane(input int n, input logic [2:0] x);
    ev_inc[3*n +: 3] = x;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; failures++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd(8'h10, v); chk("R1 gp0", v, 0);
    rd(8'h22, v); chk("R1 fix2", v, 0);
    rd(8'h31, v); chk("R1 gctl", v, 0);
    rd(8'h32, v); chk("R1 gstat", v, 0);
    chk("R1 irq", {63'b0, irq}, 0);
    chk("R1 err", {63'b0, reg_err}, 0);

    // R8 / R9 vector table
    for (int i = 0; i < 6; i++) begin
      wr(VA[i], VD[i]);
      chk(VA[i] == 8'h10 ? "R8 err" : "R9 err", {63'b0, reg_err}, {63'b0, VR[i]});
      rd(8'h10, v); chk(VA[i] == 8'h10 ? "R8 legacy rd" : "R9 legacy rd", v, VE[i]);
      rd(8'h18, v); chk(VA[i] == 8'h10 ? "R8 full rd" : "R9 full rd", v, VE[i]);
    end

    // R2 counting with enable and level filter
    wr(8'h00, 64'h0009_0002);
    wr(8'h31, 64'h1);
    wr(8'h10, 64'h0);
    @(negedge clk); lane(2, 3'd5); lane(1, 3'd7);
    repeat (3) @(negedge clk);
    ev_inc = '0;
    rd(8'h10, v); chk("R2 lane count", v, 15);
    priv_user = 1'b1; lane(2, 3'd5);
    repeat (2) @(negedge clk);
    ev_inc = '0;
    rd(8'h10, v); chk("R2 user filtered", v, 15);
    wr(8'h00, 64'h000B_0002);
    lane(2, 3'd5);
    repeat (2) @(negedge clk);
    ev_inc = '0;
    rd(8'h10, v); chk("R2 user counted", v, 25);

    // R3 global gate and fixed mapping; R4 nibbles
    wr(8'h31, 64'h0);
    priv_user = 1'b0; lane(2, 3'd5);
    repeat (2) @(negedge clk);
    ev_inc = '0;
    rd(8'h10, v); chk("R3 gated gp", v, 25);
    wr(8'h30, 64'h021);
    wr(8'h31, 64'h2_0000_0000);
    priv_user = 1'b1; fix_inc = {3'd0, 3'd4, 3'd4};
    repeat (2) @(negedge clk);
    fix_inc = '0;
    rd(8'h21, v); chk("R4 fixed1 user", v, 8);
    rd(8'h20, v); chk("R3 fixed0 gated", v, 0);

    // R5 threshold
    wr(8'h00, 64'h0049_0002);
    wr(8'h31, 64'h1);
    wr(8'h10, 64'h0);
    priv_user = 1'b0;
    lane(2, 3'd3); @(negedge clk);
    lane(2, 3'd5); @(negedge clk);
    lane(2, 3'd7); @(negedge clk);
    lane(2, 3'd4); @(negedge clk);
    ev_inc = '0;
    rd(8'h10, v); chk("R5 threshold", v, 3);

    // R6 overflow without interrupt
    wr(8'h00, 64'h0009_0002);
    wr(8'h10, 64'hFFFF_FFFF);
    lane(2, 3'd1); @(negedge clk); ev_inc = '0;
    rd(8'h10, v); chk("R6 wrap", v, 0);
    rd(8'h32, v); chk("R6 status", v, 64'h1);
    chk("R7 no irq", {63'b0, irq}, 0);
    wr(8'h33, 64'h1);
    rd(8'h32, v); chk("R6 cleared", v, 0);

    // R7 overflow with interrupt
    wr(8'h00, 64'h000D_0002);
    wr(8'h10, 64'hFFFF_FFFF);
    lane(2, 3'd1); @(negedge clk); ev_inc = '0;
    chk("R7 irq set", {63'b0, irq}, 1);
    wr(8'h33, 64'h1);
    chk("R7 irq cleared", {63'b0, irq}, 0);

    // R6 / R7 fixed counter overflow
    wr(8'h30, 64'h900);
    wr(8'h31, 64'h4_0000_0000);
    wr(8'h22, 64'h0000_FFFF_FFFF_FFFF);
    fix_inc = {3'd2, 3'd0, 3'd0}; @(negedge clk); fix_inc = '0;
    rd(8'h22, v); chk("R6 fixed wrap", v, 1);
    rd(8'h32, v); chk("R6 fixed status", v, 64'h4_0000_0000);
    chk("R7 fixed irq", {63'b0, irq}, 1);
    wr(8'h33, 64'h4_0000_0000);

    // R6 overflow beats clear in the same cycle
    wr(8'h00, 64'h0009_0002);
    wr(8'h31, 64'h1);
    wr(8'h10, 64'hFFFF_FFFF);
    @(negedge clk);
    lane(2, 3'd1); reg_wr = 1'b1; reg_addr = 8'h33; reg_wdata = 64'h1;
    @(negedge clk);
    ev_inc = '0; reg_wr = 1'b0;
    rd(8'h32, v); chk("R6 set beats clear", v, 64'h1);
    wr(8'h33, 64'h1);

    // R10 read-index port
    wr(8'h31, 64'h0);
    wr(8'h18, 64'h0000_0123_4567_89AB);
    wr(8'h21, 64'h0000_0ABC_DEF0_1234);
    rd_idx = 32'h0000_0000; #1 chk("R10 gp full", rd_data, 64'h0123_4567_89AB);
    rd_idx = 32'h8000_0000; #1 chk("R10 gp fast", rd_data, 64'h4567_89AB);
    rd_idx = 32'h4000_0001; #1 chk("R10 fixed full", rd_data, 64'h0ABC_DEF0_1234);
    rd_idx = 32'hC000_0001; #1 chk("R10 fixed fast", rd_data, 64'hDEF0_1234);
    chk("R10 no err", {63'b0, rd_err}, 0);
    rd_idx = 32'd64; #1 chk("R10 err 64", {63'b0, rd_err}, 1);
    chk("R10 err data", rd_data, 0);
    rd_idx = 32'd4; #1 chk("R10 err gp4", {63'b0, rd_err}, 1);
    rd_idx = 32'h4000_0003; #1 chk("R10 err fix3", {63'b0, rd_err}, 1);

    // R11 write while running
    wr(8'h31, 64'h1);
    @(negedge clk); lane(2, 3'd1);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = 64'd100;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(8'h10, v); chk("R11 write wins", v, 100);
    @(negedge clk);
    rd(8'h10, v); chk("R11 resumes", v, 101);
    ev_inc = '0;

    summary();
  end
endmodule